// File: doc/BRIEF.md
# Flash Byte Read Bridge

This block serves byte-wide reads from a slow 8-bit host bus out of an on-chip flash array that only delivers 32-bit words. It runs entirely on a fast clock that is locked at 32 times the host bus clock (PHI2), so every host clock period holds 32 fast-clock slices. The host clock enters as an ordinary input. It is synchronized and its rising and falling edges are detected in the fast domain.

On a synchronized rising edge of PHI2, if the host is addressing the flash window with a read, the bridge captures the host byte address. It then issues one word read to the flash, using the byte address with its two low bits removed. The flash answers after a fixed latency of four fast clocks. The bridge captures the word, uses the two low address bits to pick one of its four bytes, and holds that byte on the host data bus with the output enable asserted until PHI2 falls. A PHI2 rising edge that arrives while a flash read is still outstanding is ignored. If PHI2 falls before the word arrives, the cycle is abandoned and the bus is not driven.

Top module: `flash_byte_bridge`

## Requirements
- R1: After reset, data_oe and flash_rd_req are low, and they stay low until a qualifying host read is seen.
- R2: A qualifying read is host_cs=1 and host_rnw=1 at a synchronized PHI2 rising edge. PHI2 passes through two flops, and a rise is a 0 sample followed by a 1 sample. flash_rd_req is then high for exactly one fast cycle, namely the cycle after the third fast rising edge following the PHI2 rise.
- R3: During the request, flash_word_addr equals host_addr with bits 1:0 dropped.
- R4: The flash word is sampled on the fourth fast edge after the edge that sampled the request. data_oe rises right after that edge, which is the eighth fast edge after the PHI2 rise, and not earlier.
- R5: The byte lane follows host address bits 1:0. 00 gives word bits 7:0, 01 gives 15:8, 10 gives 23:16, and 11 gives 31:24.
- R6: While data_oe is high, data_out is stable. data_oe is released on the third fast edge after PHI2 falls.
- R7: A write (host_rnw=0) or an unselected cycle (host_cs=0) issues no flash request and leaves data_oe low.
- R8: No new request is issued while a read is in flight. A PHI2 rise during an outstanding read is ignored, and two requests are always at least five fast cycles apart.
- R9: If PHI2 falls before the flash word has been captured, data_oe stays low for that host cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, 32x the host bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phi2_in | input | 1 | Host bus clock, sampled asynchronously |
| host_addr | input | ADDR_W | Host byte address within the flash window |
| host_rnw | input | 1 | Host direction, 1 for read |
| host_cs | input | 1 | Flash window select from the host address decode |
| data_out | output | 8 | Byte driven toward the host data bus |
| data_oe | output | 1 | Output enable for data_out |
| flash_rd_req | output | 1 | One-cycle flash word read request |
| flash_word_addr | output | ADDR_W-2 | Flash word address |
| flash_rdata | input | 32 | Flash read word, valid at the fixed latency |

## Verification
A sequencer stuck in a busy state shows at the ports within one host period: the next read gives no request pulse and no output enable. A wrong wait count shifts the cycle in which data_oe rises. It also captures a word other than the one the flash model returns at the exact latency, so the byte is wrong at the first sample after the enable. A wrong lane decode or a stale address appears as a byte mismatch in the same host cycle. A missed fall keeps data_oe high into the low phase, which shows two fast cycles after the release point.

// File: rtl/flash_bridge_pkg.sv
// Shared types and constants for the flash byte read bridge.
// Assumes a 32-bit flash word and an 8-bit host data bus.
package flash_bridge_pkg;
    localparam int unsigned HOST_DW  = 8;
    localparam int unsigned FLASH_DW = 32;
    localparam int unsigned N_LANES  = FLASH_DW / HOST_DW;
    localparam int unsigned LANE_W   = $clog2(N_LANES);

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REQ  = 2'd1,
        SEQ_WAIT = 2'd2,
        SEQ_HOLD = 2'd3
    } seq_state_t;
endpackage

// File: rtl/phi_edge_sync.sv
// Brings the asynchronous host clock into the fast domain through a
// STAGES-deep flop chain, then reports one-cycle rise and fall strobes.
// Assumes the host clock is much slower than clk (high and low for several cycles).
module phi_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic phi_async,
    output logic phi_level,
    output logic phi_rise,
    output logic phi_fall
);
    localparam int unsigned CHAIN = STAGES + 1;

    logic [CHAIN-1:0] chain_q;

    // Shift the host clock through the synchronizer plus one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[CHAIN-2:0], phi_async};
        end
    end

    // Current synchronized level and edges against the previous sample.
    always_comb begin
        phi_level = chain_q[STAGES-1];
        phi_rise  = chain_q[STAGES-1] & ~chain_q[STAGES];
        phi_fall  = ~chain_q[STAGES-1] & chain_q[STAGES];
    end
endmodule

// File: rtl/flash_read_seq.sv
// Read sequencer: on a qualifying host clock rise, latches the byte
// address and pulses a word request. It waits a fixed LAT cycles, captures the
// word and enables the bus until the host clock falls. It accepts no new
// request while one is outstanding. Assumes the flash returns data exactly
// LAT edges after the edge that sampled the request.
module flash_read_seq
    import flash_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned LAT    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phi_rise,
    input  logic                phi_fall,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_rnw,
    input  logic                host_cs,
    input  logic [FLASH_DW-1:0] flash_rdata,
    output logic                flash_rd_req,
    output logic [ADDR_W-3:0]   flash_word_addr,
    output logic [LANE_W-1:0]   lane_sel,
    output logic [FLASH_DW-1:0] word_q,
    output logic                bus_oe
);
    localparam int unsigned CNT_W = $clog2(LAT + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

    seq_state_t        state_q;
    logic [CNT_W-1:0]  wait_cnt_q;
    logic              abort_q;
    logic [ADDR_W-1:0] addr_q;

    // Main sequencer: request, fixed-latency wait, hold until the host clock falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= SEQ_IDLE;
            wait_cnt_q   <= '0;
            abort_q      <= 1'b0;
            addr_q       <= '0;
            word_q       <= '0;
            flash_rd_req <= 1'b0;
            bus_oe       <= 1'b0;
        end else begin
            flash_rd_req <= 1'b0;
            case (state_q)
                SEQ_IDLE: begin
                    if (phi_rise && host_cs && host_rnw) begin
                        addr_q       <= host_addr;
                        flash_rd_req <= 1'b1;
                        abort_q      <= 1'b0;
                        state_q      <= SEQ_REQ;
                    end
                end
                SEQ_REQ: begin
                    wait_cnt_q <= '0;
                    if (phi_fall) abort_q <= 1'b1;
                    state_q <= SEQ_WAIT;
                end
                SEQ_WAIT: begin
                    if (phi_fall) abort_q <= 1'b1;
                    if (wait_cnt_q == CNT_LAST) begin
                        word_q <= flash_rdata;
                        if (abort_q || phi_fall) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            bus_oe  <= 1'b1;
                            state_q <= SEQ_HOLD;
                        end
                    end else begin
                        wait_cnt_q <= wait_cnt_q + 1'b1;
                    end
                end
                SEQ_HOLD: begin
                    if (phi_fall) begin
                        bus_oe  <= 1'b0;
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // Word address and lane come from the latched byte address.
    always_comb begin
        flash_word_addr = addr_q[ADDR_W-1:2];
        lane_sel        = addr_q[LANE_W-1:0];
    end
endmodule

// File: rtl/byte_lane_pick.sv
// Splits a flash word into host-width lanes (lane 0 = least significant)
// and returns the lane chosen by the select input. Purely combinational.
module byte_lane_pick
    import flash_bridge_pkg::*;
(
    input  logic [FLASH_DW-1:0] word_in,
    input  logic [LANE_W-1:0]   sel,
    output logic [HOST_DW-1:0]  byte_out
);
    logic [HOST_DW-1:0] lanes [N_LANES];

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign lanes[g] = word_in[g*HOST_DW +: HOST_DW];
    end

    // Select the addressed lane.
    always_comb begin
        byte_out = lanes[sel];
    end
endmodule

// File: rtl/flash_byte_bridge.sv
// Top of the flash byte read bridge. Synchronizes the host clock, runs the
// fixed-latency word read sequencer and narrows the captured word to a byte.
// Assumes clk is locked at 32x the host clock and the flash latency is LAT.
module flash_byte_bridge
    import flash_bridge_pkg::*;
#(
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned LAT         = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phi2_in,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_rnw,
    input  logic                host_cs,
    output logic [7:0]          data_out,
    output logic                data_oe,
    output logic                flash_rd_req,
    output logic [ADDR_W-3:0]   flash_word_addr,
    input  logic [31:0]         flash_rdata
);
    logic                phi_level;
    logic                phi_rise;
    logic                phi_fall;
    logic [LANE_W-1:0]   lane_sel;
    logic [FLASH_DW-1:0] word_q;

    phi_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .phi_async (phi2_in),
        .phi_level (phi_level),
        .phi_rise  (phi_rise),
        .phi_fall  (phi_fall)
    );

    flash_read_seq #(.ADDR_W(ADDR_W), .LAT(LAT)) u_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .phi_rise        (phi_rise),
        .phi_fall        (phi_fall),
        .host_addr       (host_addr),
        .host_rnw        (host_rnw),
        .host_cs         (host_cs),
        .flash_rdata     (flash_rdata),
        .flash_rd_req    (flash_rd_req),
        .flash_word_addr (flash_word_addr),
        .lane_sel        (lane_sel),
        .word_q          (word_q),
        .bus_oe          (data_oe)
    );

    byte_lane_pick u_pick (
        .word_in  (word_q),
        .sel      (lane_sel),
        .byte_out (data_out)
    );
endmodule

// File: rtl/flash_bridge_chk.sv
// Protocol checker for the flash byte read bridge, bound to the top module.
// Watches the request pulse spacing, enable timing and held data.
module flash_bridge_chk #(
    parameter int unsigned LAT = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       req,
    input logic       oe,
    input logic [7:0] dout,
    input logic       phi_s
);
    localparam int unsigned GAP_W = $clog2(LAT + 2) + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;

    logic [GAP_W-1:0] gap_q;

    // Cycles since the last request, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= GAP_MAX;
        else if (req) gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!oe && !req));

    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    // R8
    req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (gap_q >= GAP_W'(LAT)));

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && $past(oe)) |-> $stable(dout));

    // R4
    oe_in_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> phi_s);

    // R6
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> !phi_s);
endmodule

bind flash_byte_bridge flash_bridge_chk #(.LAT(LAT)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (flash_rd_req),
    .oe    (data_oe),
    .dout  (data_out),
    .phi_s (phi_level)
);

// File: tb/tb_flash_byte_bridge.sv
// Bench: 125 MHz fast clock, host clock at 1/32, fixed-latency flash model.
module tb_flash_byte_bridge;
    localparam int ADDR_W = 12;
    localparam int LAT    = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              phi2 = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic              host_rnw = 1'b1;
    logic              host_cs = 1'b0;
    logic [7:0]        data_out;
    logic              data_oe;
    logic              flash_rd_req;
    logic [ADDR_W-3:0] flash_word_addr;
    logic [31:0]       flash_rdata;

    int checks = 0;
    int errors = 0;
    int pcount = 0;
    int req_cnt = 0;
    int req_at = 0;
    logic [ADDR_W-3:0] req_addr = '0;
    logic [31:0] pipe [LAT];

    always #4 clk = ~clk;

    flash_byte_bridge #(.ADDR_W(ADDR_W), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .phi2_in(phi2), .host_addr(host_addr),
        .host_rnw(host_rnw), .host_cs(host_cs), .data_out(data_out),
        .data_oe(data_oe), .flash_rd_req(flash_rd_req),
        .flash_word_addr(flash_word_addr), .flash_rdata(flash_rdata)
    );

    function automatic logic [31:0] word_of(input logic [ADDR_W-3:0] wa);
        return (32'h9E3779B9 * ({22'd0, wa} + 32'd1)) ^ {wa[7:0], 8'h5A, wa[7:0], 8'hC3};
    endfunction

    function automatic logic [7:0] byte_of(input logic [ADDR_W-1:0] a);
        logic [31:0] w;
        w = word_of(a[ADDR_W-1:2]);
        return w[8*a[1:0] +: 8];
    endfunction

    // Flash model: word appears on rdata LAT edges after the request edge.
    always @(posedge clk) begin
        pipe[0] <= flash_rd_req ? word_of(flash_word_addr) : 32'd0;
        for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
    end
    assign flash_rdata = pipe[LAT-1];

    always @(posedge clk) pcount <= pcount + 1;

    // Request monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (flash_rd_req) begin
            req_cnt  = req_cnt + 1;
            req_at   = pcount;
            req_addr = flash_word_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One normal host cycle: 16 fast cycles high, 16 low.
    task automatic host_cycle(input logic [ADDR_W-1:0] a, input logic rnw, input logic cs);
        int r;
        logic rd;
        rd = rnw & cs;
        @(negedge clk);
        host_addr = a; host_rnw = rnw; host_cs = cs;
        req_cnt = 0;
        r = pcount;
        phi2 = 1'b1;
        wait_neg(7);
        check("R4 oe low before latency", {31'd0, data_oe}, 32'd0);
        wait_neg(1);
        check(rd ? "R4 oe after latency" : "R7 oe stays low", {31'd0, data_oe}, {31'd0, rd});
        if (rd) check("R5 byte lane", {24'd0, data_out}, {24'd0, byte_of(a)});
        wait_neg(7);
        if (rd) check("R6 held byte", {23'd0, data_oe, data_out}, {23'd0, 1'b1, byte_of(a)});
        wait_neg(1);
        phi2 = 1'b0;
        wait_neg(2);
        check("R6 oe before release", {31'd0, data_oe}, {31'd0, rd});
        wait_neg(2);
        check("R6 oe released", {31'd0, data_oe}, 32'd0);
        check(rd ? "R2 one request" : "R7 no request", req_cnt, rd ? 1 : 0);
        if (rd) begin
            check("R2 request timing", req_at - r, 3);
            check("R3 word address", {22'd0, req_addr}, {22'd0, a[ADDR_W-1:2]});
        end
        wait_neg(12);
    endtask

    initial begin
        void'($urandom(32'd1179));
        wait_neg(3);
        // R1: reset state
        check("R1 oe in reset", {31'd0, data_oe}, 32'd0);
        check("R1 req in reset", {31'd0, flash_rd_req}, 32'd0);
        rst_n = 1'b1;
        wait_neg(20);
        check("R1 oe after reset", {31'd0, data_oe}, 32'd0);
        check("R1 no request after reset", req_cnt, 0);

        // R5: every lane of one word, plus address extremes
        for (int l = 0; l < 4; l++) host_cycle(ADDR_W'(12'h2A4 + l), 1'b1, 1'b1);
        host_cycle('0, 1'b1, 1'b1);
        host_cycle('1, 1'b1, 1'b1);
        // R7: write and unselected cycles
        host_cycle(12'h123, 1'b0, 1'b1);
        host_cycle(12'h456, 1'b1, 1'b0);

        // R8/R9: short high pulse, then a second rise while the read is outstanding
        @(negedge clk);
        host_addr = 12'h3C1; host_rnw = 1'b1; host_cs = 1'b1;
        req_cnt = 0;
        phi2 = 1'b1;
        wait_neg(2); phi2 = 1'b0;
        wait_neg(2); phi2 = 1'b1;
        wait_neg(10);
        check("R8 rise while busy ignored", req_cnt, 1);
        check("R9 aborted cycle not driven", {31'd0, data_oe}, 32'd0);
        wait_neg(12);
        check("R9 still not driven", {31'd0, data_oe}, 32'd0);
        phi2 = 1'b0;
        wait_neg(16);

        // Random mix of reads, writes and deselects
        for (int k = 0; k < 80; k++) begin
            logic [ADDR_W-1:0] a;
            logic rw, cs;
            a  = ADDR_W'($urandom);
            rw = ($urandom % 5) != 0;
            cs = ($urandom % 6) != 0;
            host_cycle(a, rw, cs);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule